// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the control front end of an asynchronous-style dynamic memory device, rebuilt as synchronous logic running on an internal sampling clock. The row strobe, column strobe and write strobe arrive already synchronised, one sample per clock. The block compares each sample with the one before it to find strobe edges. From the order of those edges it works out what kind of memory cycle the controller has started. It also owns the internal refresh row counter and the enable for the data output driver.

When the row strobe falls, the block does one of two things. If the column strobe is still high, it opens a normal row access and captures the row from the address pins. If the column strobe is already low, it starts an internal refresh, and the counter supplies the row. A refresh started this way is a counter refresh, a hidden refresh, or a test-mode entry, depending on the column-strobe history and the write strobe. A counter refresh or hidden refresh turns into self-refresh if the row strobe stays low long enough. Leaving self-refresh needs a stretched recovery time. The array, the sense path and all analog timing limits belong to other blocks.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset the cycle code is 0 (idle), the refresh row is 0, and `row_le`, `col_le` and `dq_oe` are all low.
- R2: A row-strobe fall with the column strobe high sets the cycle code to 1 (row access). It raises `row_le` for exactly one clock, and `row_addr` takes the address present at that edge.
- R3: A column-strobe fall while the row strobe is low in a row access raises `col_le` for one clock. If the write strobe is high it is a read: the output data becomes valid, and `dq_oe` equals that valid state gated by `oe_n` low. A column fall with the write strobe low is a write and leaves the output off.
- R4: A row-strobe fall with the column strobe low, the write strobe high and no held read or write sets the cycle code to 2 (counter refresh). `row_addr` then shows the refresh row, the address pins are ignored, and `row_le` stays low.
- R5: The same fall with the write strobe low sets the cycle code to 4 (test entry). The refresh row does not advance when that cycle ends.
- R6: A row-strobe fall while the column strobe has stayed low since a column fall of a row access sets the cycle code to 3 (hidden refresh), whatever the write strobe. The output data of the earlier read stays driven.
- R7: When the row strobe rises to end a row access that had no column fall, the cycle code becomes 6 (row-only refresh) and `dq_oe` stays low.
- R8: The refresh row advances by one on the row-strobe rise that ends a cycle with code 2, 3 or 5, and wraps from ROWS-1 to 0. Rows never advance at any other time, except by the self-refresh interval in R9.
- R9: If the row strobe stays low for SR_ENTRY_CYC clocks after the fall of a cycle with code 2 or 3, the cycle code becomes 5 (self-refresh). While the strobe stays low, the refresh row then advances once every SR_STEP_CYC clocks.
- R10: A row-strobe rise out of self-refresh sets the cycle code to 7 (recovery) for SR_PRECH_CYC clocks, and then to 0. A row-strobe fall during recovery starts no cycle.
- R11: Valid output data turns off only when both strobes are high. A column rise with the row strobe low keeps it on, and so does a row rise with the column strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe sample, active low |
| cas_n | input | 1 | Column strobe sample, active low |
| we_n | input | 1 | Write strobe sample, active low |
| oe_n | input | 1 | Output enable pin, active low |
| addr | input | ADDR_W | Multiplexed address pins |
| cyc_type | output | 3 | Current or last cycle code (0 idle, 1 access, 2 counter refresh, 3 hidden, 4 test entry, 5 self-refresh, 6 row-only, 7 recovery) |
| row_addr | output | ADDR_W | Row chosen for the current cycle |
| refresh_row | output | clog2(ROWS) | Internal refresh row counter |
| row_le | output | 1 | One-clock row latch enable |
| col_le | output | 1 | One-clock column latch enable |
| dq_oe | output | 1 | Data output driver enable |

## Verification
The hardest state to reach is recovery from self-refresh with a stray row-strobe fall inside the recovery window. To get there, the bench must first hold a counter refresh low past the entry threshold and then let the interval timer step the row counter. It then releases the strobe and pulses it low again within SR_PRECH_CYC clocks. Small parameter overrides keep that path short, so every transition is checked at an exact clock. Hidden refresh needs a similar sequence: a read has to leave the column strobe low across a row-strobe precharge, and the bench holds the write strobe low at the second fall to show that the test-entry decode loses priority.

// File: rtl/strobe_cycle_decoder_pkg.sv
`timescale 1ns/1ps
package strobe_cycle_decoder_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE     = 3'd0,
      CYC_ACCESS   = 3'd1,
      CYC_CBR      = 3'd2,
      CYC_HIDDEN   = 3'd3,
      CYC_TEST     = 3'd4,
      CYC_SELF     = 3'd5,
      CYC_RAS_ONLY = 3'd6,
      CYC_SR_EXIT  = 3'd7
   } cyc_kind_t;

endpackage

// File: rtl/sdc_strobe_edges.sv
`timescale 1ns/1ps
module sdc_strobe_edges #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strobe_n,
   output logic [N-1:0] held_n,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);

   if (N < 1) begin : g_bad_n
      $error("sdc_strobe_edges: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) held_n[i] <= 1'b1;
         else        held_n[i] <= strobe_n[i];
      end
      assign fall[i] = held_n[i] & ~strobe_n[i];
      assign rise[i] = ~held_n[i] & strobe_n[i];
   end

endmodule

// File: rtl/sdc_span_timer.sv
`timescale 1ns/1ps
module sdc_span_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic done
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("sdc_span_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign done = run & ~clear & (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (run) begin
         if (done) cnt <= '0;
         else      cnt <= cnt + 1'b1;
      end
   end

   assert_span_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/sdc_refresh_row.sv
`timescale 1ns/1ps
module sdc_refresh_row #(
   parameter int ROWS = 4096
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     inc,
   output logic [$clog2(ROWS)-1:0]  row
);

   localparam int  RW      = $clog2(ROWS);
   localparam bit  IS_POW2 = ((ROWS & (ROWS - 1)) == 0);

   if (ROWS < 2) begin : g_bad_rows
      $error("sdc_refresh_row: ROWS must be at least 2");
   end

   if (IS_POW2) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   row <= '0;
         else if (inc) row <= row + 1'b1;
      end
   end else begin : g_mod
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) row <= '0;
         else if (inc) begin
            if (row == RW'(ROWS - 1)) row <= '0;
            else                      row <= row + 1'b1;
         end
      end
   end

   assert_row_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(row));

   assert_row_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && row == RW'(ROWS - 1)) |=> (row == '0));

   assert_row_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      row <= RW'(ROWS - 1));

endmodule

// File: rtl/strobe_cycle_decoder.sv
`timescale 1ns/1ps
module strobe_cycle_decoder
   import strobe_cycle_decoder_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int ROWS         = 4096,
   parameter int SR_ENTRY_CYC = 5000,
   parameter int SR_STEP_CYC  = 781,
   parameter int SR_PRECH_CYC = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ras_n,
   input  logic                     cas_n,
   input  logic                     we_n,
   input  logic                     oe_n,
   input  logic [ADDR_W-1:0]        addr,
   output logic [2:0]               cyc_type,
   output logic [ADDR_W-1:0]        row_addr,
   output logic [$clog2(ROWS)-1:0]  refresh_row,
   output logic                     row_le,
   output logic                     col_le,
   output logic                     dq_oe
);

   localparam int RW = $clog2(ROWS);

   if (ADDR_W < RW) begin : g_bad_width
      $error("strobe_cycle_decoder: ADDR_W too narrow for ROWS");
   end
   if (SR_PRECH_CYC < 1 || SR_STEP_CYC < 1 || SR_ENTRY_CYC < 1) begin : g_bad_time
      $error("strobe_cycle_decoder: timing limits must be positive");
   end

   // ---------------- strobe edges ----------------
   logic [1:0] st_held, st_fall, st_rise;
   sdc_strobe_edges #(.N(2)) u_edges (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n ({cas_n, ras_n}),
      .held_n   (st_held),
      .fall     (st_fall),
      .rise     (st_rise)
   );

   logic ras_q, cas_q, ras_fall, ras_rise, cas_fall, cas_rise;
   assign ras_q    = st_held[0];
   assign cas_q    = st_held[1];
   assign ras_fall = st_fall[0];
   assign ras_rise = st_rise[0];
   assign cas_fall = st_fall[1];
   assign cas_rise = st_rise[1];

   // ---------------- state ----------------
   cyc_kind_t cyc_q, cyc_d, new_cls;
   logic      col_seen, cas_held, dq_valid;
   logic      row_le_q, col_le_q;
   logic [ADDR_W-1:0] row_addr_q;

   logic in_exit, in_self, refr_cls, start, col_fire;
   logic entry_run, entry_done, step_run, step_done;
   logic exit_clear, exit_done, ref_inc;

   assign in_exit  = (cyc_q == CYC_SR_EXIT);
   assign in_self  = (cyc_q == CYC_SELF);
   assign refr_cls = (cyc_q == CYC_CBR) || (cyc_q == CYC_HIDDEN);
   assign start    = ras_fall & ~in_exit;
   assign col_fire = cas_fall & ~ras_n & (cyc_q == CYC_ACCESS);

   always_comb begin
      if (cas_n)      new_cls = CYC_ACCESS;
      else if (cas_held) new_cls = CYC_HIDDEN;
      else if (!we_n) new_cls = CYC_TEST;
      else            new_cls = CYC_CBR;
   end

   // ---------------- timers ----------------
   assign entry_run = ~ras_n & refr_cls & ~ras_fall;
   sdc_span_timer #(.LIMIT(SR_ENTRY_CYC)) u_entry_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ras_fall),
      .run   (entry_run),
      .done  (entry_done)
   );

   assign step_run = in_self & ~ras_n;
   sdc_span_timer #(.LIMIT(SR_STEP_CYC)) u_step_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (entry_done),
      .run   (step_run),
      .done  (step_done)
   );

   assign exit_clear = ras_rise & in_self;
   sdc_span_timer #(.LIMIT(SR_PRECH_CYC)) u_exit_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (exit_clear),
      .run   (in_exit),
      .done  (exit_done)
   );

   // ---------------- refresh counter ----------------
   assign ref_inc = (ras_rise & (refr_cls | in_self)) | step_done;

   sdc_refresh_row #(.ROWS(ROWS)) u_refresh_row (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ref_inc),
      .row   (refresh_row)
   );

   // ---------------- cycle classification ----------------
   always_comb begin
      cyc_d = cyc_q;
      if (start)                                          cyc_d = new_cls;
      else if (entry_done)                                cyc_d = CYC_SELF;
      else if (exit_clear)                                cyc_d = CYC_SR_EXIT;
      else if (exit_done)                                 cyc_d = CYC_IDLE;
      else if (ras_rise && cyc_q == CYC_ACCESS && !col_seen) cyc_d = CYC_RAS_ONLY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q      <= CYC_IDLE;
         col_seen   <= 1'b0;
         cas_held   <= 1'b0;
         dq_valid   <= 1'b0;
         row_le_q   <= 1'b0;
         col_le_q   <= 1'b0;
         row_addr_q <= '0;
      end else begin
         cyc_q    <= cyc_d;
         row_le_q <= start & cas_n;
         col_le_q <= col_fire;

         if (start)         col_seen <= 1'b0;
         else if (col_fire) col_seen <= 1'b1;

         if (cas_rise)      cas_held <= 1'b0;
         else if (col_fire) cas_held <= 1'b1;

         if (ras_n && cas_n) dq_valid <= 1'b0;
         else if (col_fire)  dq_valid <= we_n;

         if (start) row_addr_q <= cas_n ? addr : ADDR_W'(refresh_row);
      end
   end

   assign cyc_type = cyc_q;
   assign row_addr = row_addr_q;
   assign row_le   = row_le_q;
   assign col_le   = col_le_q;
   assign dq_oe    = dq_valid & ~oe_n;

   // ---------------- assertions ----------------
   assert_rowle_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      row_le |-> (cyc_q == CYC_ACCESS));

   assert_rowle_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      row_le |=> !row_le);

   assert_colle_ras_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      col_le |-> !ras_q);

   assert_off_when_both_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_q && cas_q) |-> !dq_valid);

   assert_rasonly_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CYC_RAS_ONLY) |-> !dq_valid);

   assert_self_from_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CYC_SELF && $past(cyc_q) != CYC_SELF) |->
      ($past(cyc_q) == CYC_CBR || $past(cyc_q) == CYC_HIDDEN));

   assert_exit_ignores_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exit && ras_fall) |=> (!row_le && cyc_q inside {CYC_SR_EXIT, CYC_IDLE}));

   assert_test_no_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CYC_TEST) |=> $stable(refresh_row));

endmodule

// File: tb/strobe_cycle_decoder_bench.sv
`timescale 1ns/1ps
module strobe_cycle_decoder_bench;

   localparam int ADDR_W = 13;
   localparam int ROWS   = 5;
   localparam int SR_E   = 30;
   localparam int SR_S   = 4;
   localparam int SR_P   = 5;
   localparam int RW     = $clog2(ROWS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [2:0]        cyc_type;
   logic [ADDR_W-1:0] row_addr;
   logic [RW-1:0]     refresh_row;
   logic              row_le, col_le, dq_oe;

   int total = 0;
   int bad   = 0;
   int er    = 0;

   always #10 clk = ~clk;

   strobe_cycle_decoder #(
      .ADDR_W(ADDR_W), .ROWS(ROWS), .SR_ENTRY_CYC(SR_E),
      .SR_STEP_CYC(SR_S), .SR_PRECH_CYC(SR_P)
   ) u_strobe_cycle_decoder (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type), .row_addr(row_addr),
      .refresh_row(refresh_row), .row_le(row_le), .col_le(col_le), .dq_oe(dq_oe)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic bump();
      er = (er + 1) % ROWS;
   endtask

   task automatic t_reset();
      check("R1 cyc", int'(cyc_type), 0);
      check("R1 refresh_row", int'(refresh_row), 0);
      check("R1 row_le", int'(row_le), 0);
      check("R1 col_le", int'(col_le), 0);
      check("R1 dq_oe", int'(dq_oe), 0);
   endtask

   task automatic t_read_edo();
      addr = 13'h1A5; ras_n = 1'b0; step();
      check("R2 cyc access", int'(cyc_type), 1);
      check("R2 row_le", int'(row_le), 1);
      check("R2 row_addr", int'(row_addr), 'h1A5);
      addr = 13'h0055; step();
      check("R2 row_le pulse", int'(row_le), 0);
      check("R2 row_addr held", int'(row_addr), 'h1A5);
      we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
      check("R3 col_le", int'(col_le), 1);
      check("R3 dq_oe read", int'(dq_oe), 1);
      step();
      check("R3 col_le pulse", int'(col_le), 0);
      oe_n = 1'b1; #1;
      check("R3 oe_n gates", int'(dq_oe), 0);
      oe_n = 1'b0;
      cas_n = 1'b1; step();
      check("R11 cas rise keeps", int'(dq_oe), 1);
      ras_n = 1'b1; step();
      check("R11 both high off", int'(dq_oe), 0);
      check("R2 cyc stays access", int'(cyc_type), 1);
      check("R8 access no advance", int'(refresh_row), er);
   endtask

   task automatic t_ras_rise_first();
      ras_n = 1'b0; step();
      cas_n = 1'b0; step();
      ras_n = 1'b1; step();
      check("R11 ras rise keeps", int'(dq_oe), 1);
      cas_n = 1'b1; step();
      check("R11 cas rise last off", int'(dq_oe), 0);
   endtask

   task automatic t_write();
      ras_n = 1'b0; step();
      we_n = 1'b0; cas_n = 1'b0; step();
      check("R3 write col_le", int'(col_le), 1);
      check("R3 write dq off", int'(dq_oe), 0);
      cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; step();
   endtask

   task automatic t_ras_only();
      ras_n = 1'b0; addr = 13'h0777; step();
      check("R7 starts access", int'(cyc_type), 1);
      step(); step();
      ras_n = 1'b1; step();
      check("R7 cyc ras_only", int'(cyc_type), 6);
      check("R7 dq_oe", int'(dq_oe), 0);
      check("R8 ras_only no advance", int'(refresh_row), er);
   endtask

   task automatic t_cbr();
      cas_n = 1'b0; step();
      check("R3 cas fall idle no col_le", int'(col_le), 0);
      addr = 13'h1FFF; ras_n = 1'b0; step();
      check("R4 cyc cbr", int'(cyc_type), 2);
      check("R4 row_le low", int'(row_le), 0);
      check("R4 row_addr from counter", int'(row_addr), er);
      ras_n = 1'b1; step(); bump();
      check("R8 cbr advance", int'(refresh_row), er);
      cas_n = 1'b1; step();
   endtask

   task automatic t_test_entry();
      cas_n = 1'b0; we_n = 1'b0; step();
      ras_n = 1'b0; step();
      check("R5 cyc test", int'(cyc_type), 4);
      ras_n = 1'b1; step();
      check("R5 no advance", int'(refresh_row), er);
      cas_n = 1'b1; we_n = 1'b1; step();
   endtask

   task automatic t_hidden();
      addr = 13'h0123; ras_n = 1'b0; step();
      we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
      ras_n = 1'b1; step();
      check("R6 data before hidden", int'(dq_oe), 1);
      we_n = 1'b0; ras_n = 1'b0; step();
      check("R6 cyc hidden", int'(cyc_type), 3);
      check("R6 data kept", int'(dq_oe), 1);
      check("R6 row from counter", int'(row_addr), er);
      we_n = 1'b1; ras_n = 1'b1; step(); bump();
      check("R8 hidden advance", int'(refresh_row), er);
      check("R6 data kept after", int'(dq_oe), 1);
      cas_n = 1'b1; step();
      check("R11 hidden end off", int'(dq_oe), 0);
   endtask

   task automatic t_wrap();
      for (int k = 0; k < ROWS + 1; k++) begin
         cas_n = 1'b0; step();
         ras_n = 1'b0; step();
         ras_n = 1'b1; step(); bump();
         check("R8 wrap sequence", int'(refresh_row), er);
         cas_n = 1'b1; step();
      end
   endtask

   task automatic t_self();
      cas_n = 1'b0; we_n = 1'b1; step();
      ras_n = 1'b0; step();
      check("R9 starts cbr", int'(cyc_type), 2);
      repeat (SR_E - 1) step();
      check("R9 not yet self", int'(cyc_type), 2);
      step();
      check("R9 cyc self", int'(cyc_type), 5);
      check("R9 row at entry", int'(refresh_row), er);
      repeat (2 * SR_S) step();
      bump(); bump();
      check("R9 self stepping", int'(refresh_row), er);
      ras_n = 1'b1; step(); bump();
      check("R10 cyc recovery", int'(cyc_type), 7);
      check("R8 self exit advance", int'(refresh_row), er);
      ras_n = 1'b0; step();
      check("R10 fall ignored cyc", int'(cyc_type), 7);
      check("R10 fall ignored row_le", int'(row_le), 0);
      ras_n = 1'b1;
      repeat (SR_P - 2) step();
      check("R10 still recovering", int'(cyc_type), 7);
      step();
      check("R10 back to idle", int'(cyc_type), 0);
      check("R10 no extra advance", int'(refresh_row), er);
      cas_n = 1'b1; step();
   endtask

   initial begin
      #(20 * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_read_edo();
      t_ras_rise_first();
      t_write();
      t_ras_only();
      t_cbr();
      t_test_entry();
      t_hidden();
      t_wrap();
      t_self();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule